// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This block keeps three single-bit status flags (negative, zero, positive) for a small 16-bit processor and decides whether a conditional branch instruction is taken. A combinational classifier watches the shared data bus at all times and reports whether the value on it is negative, zero or positive. The three flag registers capture that report only on a clock edge where the controller asserts a load strobe. This happens after arithmetic, logic and load operations that write a register.

The branch decision compares the three request bits of the current instruction word with the stored flags. It is true when any requested condition matches a set flag and the instruction's opcode field shows a conditional branch. The sequencer uses this signal to decide whether the program counter takes the branch target. The target computation and the control sequencing sit outside this block. The data width and the bit positions of the opcode and request fields are parameters.

Top module: `cc_branch_unit`

## Requirements
- R1: After reset the stored flags are neg=0, zero=1, pos=0.
- R2: The classifier outputs (`cls_neg`, `cls_zero`, `cls_pos`) follow the bus combinationally. Negative means the most significant bit (bit 15) is 1. Zero means every bit is 0. Positive is every other value. Exactly one classifier output is high.
- R3: On a rising clock edge with `load_en`=1, the flags take the classifier outputs of that cycle. They are visible on the flag outputs after that edge.
- R4: On a clock edge with `load_en`=0, the flags hold their value whatever the bus carries.
- R5: After reset and after every load, exactly one of the three flags is set.
- R6: A branch instruction has opcode bits [15:12] = 4'b0000 and request bits n=[11], z=[10], p=[9]. `take_branch` = (n&neg)|(z&zero)|(p&pos) for such an instruction. It is evaluated combinationally from the stored flags.
- R7: `take_branch` is 0 whenever the opcode field is not 4'b0000.
- R8: A branch instruction with n=z=p=0 is never taken, and one with n=z=p=1 is always taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_val | input | 16 | Shared data bus value |
| load_en | input | 1 | Strobe that loads the flags from the bus classification |
| instr | input | 16 | Current instruction word |
| cls_neg | output | 1 | Live classification: bus value negative |
| cls_zero | output | 1 | Live classification: bus value zero |
| cls_pos | output | 1 | Live classification: bus value positive |
| flag_neg | output | 1 | Stored negative flag |
| flag_zero | output | 1 | Stored zero flag |
| flag_pos | output | 1 | Stored positive flag |
| take_branch | output | 1 | Conditional branch is taken |

## Verification
The bench builds the block with its default parameters: a 16-bit word, opcode in bits [15:12], request mask in bits [11:9]. With these values, the sign-bit boundaries (0x7FFF, 0x8000, 0xFFFF, 0x0001) and all eight request masks against each of the three flag states can be reached. Vectors pair bus values and strobes with instruction words. They check the live classification and the branch decision against every stored flag state. The strobe-low vectors confirm that a changing bus leaves the flags unchanged. A non-zero opcode carrying a full mask confirms that no branch is reported for other instructions.

// File: rtl/cc_branch_pkg.sv
package cc_branch_pkg;
   typedef struct packed {
      logic neg;
      logic zero;
      logic pos;
   } nzp_t;

   localparam nzp_t NZP_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/cc_sign_classify.sv
module cc_sign_classify
   import cc_branch_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] value,
   output nzp_t             cls
);
   localparam int MSB = WIDTH - 1;

   initial begin
      assert (WIDTH >= 2) else $error("cc_sign_classify: WIDTH must be at least 2");
   end

   logic is_zero;
   assign is_zero = (value == '0);

   always_comb begin
      cls.neg  = value[MSB];
      cls.zero = is_zero;
      cls.pos  = ~value[MSB] & ~is_zero;
   end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
   import cc_branch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  nzp_t d,
   output nzp_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= NZP_RESET;
      else if (load) q <= d;
   end
endmodule

// File: rtl/cc_branch_decide.sv
module cc_branch_decide
   import cc_branch_pkg::*;
#(
   parameter int                IW       = 16,
   parameter int                OP_LSB   = 12,
   parameter int                OP_W     = 4,
   parameter logic [OP_W-1:0]   BR_OP    = '0,
   parameter int                MASK_LSB = 9
) (
   input  logic [IW-1:0] instr,
   input  nzp_t          flags,
   output logic          taken
);
   localparam int OP_MSB = OP_LSB + OP_W - 1;

   initial begin
      assert (OP_MSB < IW) else $error("cc_branch_decide: opcode field outside word");
      assert (MASK_LSB + 2 < OP_LSB) else $error("cc_branch_decide: mask overlaps opcode");
   end

   logic [2:0] req;
   logic [2:0] hit;
   logic       is_br;

   assign req   = instr[MASK_LSB +: 3];
   assign is_br = (instr[OP_MSB:OP_LSB] == BR_OP);

   for (genvar i = 0; i < 3; i++) begin : g_match
      assign hit[i] = req[i] & flags[i];
   end

   assign taken = is_br & (|hit);
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
   import cc_branch_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int OP_LSB   = 12,
   parameter int MASK_LSB = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_val,
   input  logic             load_en,
   input  logic [WIDTH-1:0] instr,
   output logic             cls_neg,
   output logic             cls_zero,
   output logic             cls_pos,
   output logic             flag_neg,
   output logic             flag_zero,
   output logic             flag_pos,
   output logic             take_branch
);
   localparam int OP_W = WIDTH - OP_LSB;

   nzp_t cls_w;
   nzp_t flg_w;

   cc_sign_classify #(.WIDTH(WIDTH)) u_cls (
      .value (bus_val),
      .cls   (cls_w)
   );

   cc_flag_reg u_flg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_en),
      .d     (cls_w),
      .q     (flg_w)
   );

   cc_branch_decide #(
      .IW       (WIDTH),
      .OP_LSB   (OP_LSB),
      .OP_W     (OP_W),
      .BR_OP    ('0),
      .MASK_LSB (MASK_LSB)
   ) u_dec (
      .instr (instr),
      .flags (flg_w),
      .taken (take_branch)
   );

   assign cls_neg   = cls_w.neg;
   assign cls_zero  = cls_w.zero;
   assign cls_pos   = cls_w.pos;
   assign flag_neg  = flg_w.neg;
   assign flag_zero = flg_w.zero;
   assign flag_pos  = flg_w.pos;
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] bus_val,
   input logic             load_en,
   input logic             cls_neg,
   input logic             cls_zero,
   input logic             cls_pos,
   input logic             flag_neg,
   input logic             flag_zero,
   input logic             flag_pos
);
   AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flag_neg, flag_zero, flag_pos}) == 1); // R5

   AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cls_neg, cls_zero, cls_pos}) == 1); // R2

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (flag_neg == $past(cls_neg) && flag_zero == $past(cls_zero)
                   && flag_pos == $past(cls_pos))); // R3

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> ($stable(flag_neg) && $stable(flag_zero) && $stable(flag_pos))); // R4

   AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_val == '0) |-> cls_zero); // R2
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_val   (bus_val),
   .load_en   (load_en),
   .cls_neg   (cls_neg),
   .cls_zero  (cls_zero),
   .cls_pos   (cls_pos),
   .flag_neg  (flag_neg),
   .flag_zero (flag_zero),
   .flag_pos  (flag_pos)
);

// File: tb/sim_cc_branch_unit.sv
`timescale 1ns/1ps
module sim_cc_branch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_val = '0;
   logic        load_en = 1'b0;
   logic [15:0] instr = '0;
   logic        cls_neg, cls_zero, cls_pos;
   logic        flag_neg, flag_zero, flag_pos;
   logic        take_branch;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   cc_branch_unit u0 (
      .clk(clk), .rst_n(rst_n), .bus_val(bus_val), .load_en(load_en),
      .instr(instr), .cls_neg(cls_neg), .cls_zero(cls_zero), .cls_pos(cls_pos),
      .flag_neg(flag_neg), .flag_zero(flag_zero), .flag_pos(flag_pos),
      .take_branch(take_branch)
   );

   // vector: bus, load, instr
   localparam int NV = 12;
   localparam logic [32:0] VEC [NV] = '{
      {16'h8000, 1'b1, 16'h0800},
      {16'h7FFF, 1'b0, 16'h0800},
      {16'h0001, 1'b1, 16'h0200},
      {16'h0000, 1'b0, 16'h0C00},
      {16'h0000, 1'b1, 16'h0400},
      {16'hFFFF, 1'b0, 16'h0A00},
      {16'hFFFF, 1'b1, 16'h0600},
      {16'h7FFF, 1'b1, 16'h1E00},
      {16'h7FFF, 1'b0, 16'h0000},
      {16'h1234, 1'b0, 16'h0E00},
      {16'h0000, 1'b1, 16'hFE00},
      {16'h0000, 1'b0, 16'h0A00}
   };

   function automatic logic [2:0] classify(input logic [15:0] v);
      if (v[15]) return 3'b100;
      if (v == 16'h0) return 3'b010;
      return 3'b001;
   endfunction

   function automatic logic decide(input logic [15:0] ins, input logic [2:0] f);
      if (ins[15:12] != 4'b0000) return 1'b0;
      return |(ins[11:9] & f);
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   logic [2:0] model;

   initial begin
      #2000000;
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model = 3'b010;
      #35;
      // R1 reset state
      check("R1", {1'b0, flag_neg, flag_zero, flag_pos}, 4'b0010);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         bus_val = VEC[i][32:17];
         load_en = VEC[i][16];
         instr   = VEC[i][15:0];
         #1;
         check("R2", {1'b0, cls_neg, cls_zero, cls_pos}, {1'b0, classify(bus_val)});
         check("R6", {3'b0, take_branch}, {3'b0, decide(instr, model)});
         @(posedge clk);
         if (load_en) model = classify(bus_val);
         @(negedge clk);
         check(load_en ? "R3" : "R4", {1'b0, flag_neg, flag_zero, flag_pos}, {1'b0, model});
         check("R5", {3'b0, $countones({flag_neg, flag_zero, flag_pos}) == 1}, 4'b0001);
      end
      // R8 empty and full masks against each flag state
      load_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         bus_val = (k == 0) ? 16'h8000 : (k == 1) ? 16'h0000 : 16'h0042;
         @(posedge clk);
         @(negedge clk);
         instr = 16'h0000; #1;
         check("R8", {3'b0, take_branch}, 4'b0000);
         instr = 16'h0E00; #1;
         check("R8", {3'b0, take_branch}, 4'b0001);
         instr = 16'h9E00; #1;
         check("R7", {3'b0, take_branch}, 4'b0000);
      end
      load_en = 1'b0;
      // R1 reset again mid-run after a positive load
      rst_n = 1'b0; #1;
      check("R1", {1'b0, flag_neg, flag_zero, flag_pos}, 4'b0010);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule